// File: doc/BRIEF.md
# Shader Operand Fetch and Swizzle Stage

This block reads operands for, and writes results from, a small shader core that works on vectors of four components. Each component is an opaque 24-bit word. The block does no arithmetic, instruction fetch or flow control.

When an instruction issues, two 7-bit source addresses are decoded into register classes. The classes are input attributes, temporaries and constant uniforms. The block reads the selected 4-component vectors and reorders each source through 2-bit lane selectors. The selectors come from a swizzle pattern, and an operand-descriptor index in the instruction picks that pattern from a table. The pattern can also negate the first source.

On write-back, a result vector goes to an output or temporary register. Only the components whose enable bits are set in the pattern are written. Input attributes and uniforms are filled through a separate load port. The pattern table has its own write port. Output registers are read back through a one-cycle read port.

Top module: `shd_operand_stage`

## Requirements
- R1: Source 1 address decode. 0x00–0x0F reads input register addr[3:0]. 0x10–0x1F reads temporary addr[3:0]. 0x20–0x7F reads uniform addr−0x20, of 96 uniforms.
- R2: Source 2 address decode. 0x00–0x0F reads input register addr[3:0]. Any other value reads temporary addr[3:0].
- R3: A vector holds component i (i = 0..3) in bits [24i+23:24i]. Pattern bits [5+2i+1:5+2i] pick the source-1 component that feeds result lane i. Pattern bits [13+2i+1:13+2i] do the same for source 2.
- R4: When pattern bit 4 is set, bit 23 of all four swizzled source-1 components is inverted. Source 2 is never altered.
- R5: A write-back to destination 0x00–0x06 targets output register dst. A write-back to 0x10–0x1F targets temporary dst[3:0]. Component i is written only when pattern bit i is set (bits [3:0]), and the other components keep their value.
- R6: A write-back to destination 0x07–0x0F or 0x20–0x7F changes no output and no temporary.
- R7: Both swizzled operands are registered, and opnd_valid is set on the clock edge after an edge with issue_valid high. Without issue_valid, opnd_valid is low and the operands keep their last value.
- R8: When an issue and a write-back to the register it reads happen at the same edge, the issue returns the value from before the write.
- R9: The load port writes input register addr[3:0] for 0x00–0x0F and uniform addr−0x20 for 0x20–0x7F. Load addresses 0x10–0x1F are ignored.
- R10: out_rd_data shows output register out_rd_idx one clock edge after the index is presented.
- R11: Synchronous reset clears opnd_valid, both operands, out_rd_data and every input, uniform, temporary and output register. The pattern table is not cleared.
- R12: The pattern table holds 1024 entries of 21 bits. An entry written at one edge can be used by an issue or write-back at any later edge, including index 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_we | input | 1 | Pattern table write enable |
| pat_waddr | input | 10 | Pattern table write index |
| pat_wdata | input | 21 | Pattern entry: mask [3:0], negate [4], source-1 selectors [12:5], source-2 selectors [20:13] |
| ld_we | input | 1 | Load port write enable |
| ld_addr | input | 7 | Load address (input or uniform range) |
| ld_data | input | 96 | Vector to load |
| issue_valid | input | 1 | Instruction issue strobe |
| src1_addr | input | 7 | Source 1 register address |
| src2_addr | input | 7 | Source 2 register address |
| issue_desc | input | 10 | Pattern index for the issued instruction |
| opnd_valid | output | 1 | Operands below are from the previous issue edge |
| opnd_a | output | 96 | Swizzled, optionally negated source 1 |
| opnd_b | output | 96 | Swizzled source 2 |
| wb_valid | input | 1 | Write-back strobe |
| wb_dst | input | 7 | Destination register address |
| wb_desc | input | 10 | Pattern index that supplies the write mask |
| wb_data | input | 96 | Result vector |
| out_rd_idx | input | 3 | Output register to read back |
| out_rd_data | output | 96 | Registered output register contents |

## Verification
The operands of an issue are due one clock edge after the issue edge. Output read-back is due one edge after the index is presented. A write-back becomes visible to operand reads from the next issue edge. The bench drives every input on the falling edge and samples one falling edge later, so each check lands half a period after the edge that produces its result. A bench-side model computes the expected values from the address map, the pattern fields and the write masks. Read-before-write is checked by placing an issue and a write-back to the same temporary on one edge.

// File: rtl/shd_pkg.sv
package shd_pkg;
  localparam int ADDR_W   = 7;
  localparam int TMP_BASE = 16;
  localparam int UNI_BASE = 32;
  localparam int TMP_END  = 32;

  // pattern entry field positions
  localparam int MASK_LSB = 0;
  localparam int NEG_BIT  = 4;
  localparam int S1_LSB   = 5;
  localparam int S2_LSB   = 13;

  typedef enum logic [2:0] {
    CLS_IN, CLS_TMP, CLS_UNI, CLS_OUT, CLS_NONE
  } rclass_e;

  function automatic rclass_e src1_class(input logic [ADDR_W-1:0] a);
    if (int'(a) < TMP_BASE)      return CLS_IN;
    else if (int'(a) < UNI_BASE) return CLS_TMP;
    else                         return CLS_UNI;
  endfunction

  function automatic rclass_e dst_class(input logic [ADDR_W-1:0] a, input int n_out);
    if (int'(a) < n_out)                              return CLS_OUT;
    else if (int'(a) >= TMP_BASE && int'(a) < TMP_END) return CLS_TMP;
    else                                               return CLS_NONE;
  endfunction
endpackage

// File: rtl/shd_pattern_ram.sv
module shd_pattern_ram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 21,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // two asynchronous read ports: distributed RAM
  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/shd_swizzle.sv
module shd_swizzle #(
  parameter int CW  = 24,
  parameter int NC  = 4,
  localparam int SW = $clog2(NC),
  localparam int VW = CW * NC
) (
  input  logic [VW-1:0]    vec_i,
  input  logic [NC*SW-1:0] sel_i,
  input  logic             neg_i,
  output logic [VW-1:0]    vec_o
);
  logic [CW-1:0] lanes [NC];

  for (genvar c = 0; c < NC; c++) begin : g_lane
    assign lanes[c] = vec_i[c*CW +: CW];
  end

  for (genvar c = 0; c < NC; c++) begin : g_pick
    logic [CW-1:0] picked;
    assign picked = lanes[sel_i[c*SW +: SW]];
    assign vec_o[c*CW +: CW] = {picked[CW-1] ^ neg_i, picked[CW-2:0]};
  end
endmodule

// File: rtl/shd_operand_stage.sv
module shd_operand_stage
  import shd_pkg::*;
#(
  parameter int CW        = 24,
  parameter int NC        = 4,
  parameter int AW        = ADDR_W,
  parameter int N_IN      = 16,
  parameter int N_TMP     = 16,
  parameter int N_UNI     = 96,
  parameter int N_OUT     = 7,
  parameter int PAT_DEPTH = 1024,
  parameter int PAT_W     = 21,
  localparam int VW  = CW * NC,
  localparam int PIW = $clog2(PAT_DEPTH),
  localparam int OIW = $clog2(N_OUT),
  localparam int IIW = $clog2(N_IN),
  localparam int TIW = $clog2(N_TMP),
  localparam int UIW = $clog2(N_UNI),
  localparam int SW  = $clog2(NC)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pat_we,
  input  logic [PIW-1:0] pat_waddr,
  input  logic [PAT_W-1:0] pat_wdata,
  input  logic           ld_we,
  input  logic [AW-1:0]  ld_addr,
  input  logic [VW-1:0]  ld_data,
  input  logic           issue_valid,
  input  logic [AW-1:0]  src1_addr,
  input  logic [AW-1:0]  src2_addr,
  input  logic [PIW-1:0] issue_desc,
  output logic           opnd_valid,
  output logic [VW-1:0]  opnd_a,
  output logic [VW-1:0]  opnd_b,
  input  logic           wb_valid,
  input  logic [AW-1:0]  wb_dst,
  input  logic [PIW-1:0] wb_desc,
  input  logic [VW-1:0]  wb_data,
  input  logic [OIW-1:0] out_rd_idx,
  output logic [VW-1:0]  out_rd_data
);
  logic [N_IN-1:0][VW-1:0]  in_q;
  logic [N_UNI-1:0][VW-1:0] uni_q;
  logic [N_TMP-1:0][VW-1:0] tmp_q;
  logic [N_OUT-1:0][VW-1:0] out_q;

  logic [PAT_W-1:0] pat_rd, pat_wb;

  shd_pattern_ram #(.DEPTH(PAT_DEPTH), .DW(PAT_W)) pat_i (
    .clk(clk), .we(pat_we), .waddr(pat_waddr), .wdata(pat_wdata),
    .ra_addr(issue_desc), .ra_data(pat_rd),
    .rb_addr(wb_desc), .rb_data(pat_wb)
  );

  // source fetch
  logic [VW-1:0]  s1_vec, s2_vec, s1_swz, s2_swz;
  logic [UIW-1:0] s1_uni;

  always_comb begin
    s1_vec = '0;
    s1_uni = UIW'(src1_addr - AW'(UNI_BASE));
    unique case (src1_class(src1_addr))
      CLS_IN:  s1_vec = in_q[IIW'(src1_addr)];
      CLS_TMP: s1_vec = tmp_q[TIW'(src1_addr)];
      CLS_UNI: if (s1_uni < UIW'(N_UNI)) s1_vec = uni_q[s1_uni];
      default: s1_vec = '0;
    endcase
  end

  always_comb begin
    if (int'(src2_addr) < TMP_BASE) s2_vec = in_q[IIW'(src2_addr)];
    else                            s2_vec = tmp_q[TIW'(src2_addr)];
  end

  shd_swizzle #(.CW(CW), .NC(NC)) swz_a_i (
    .vec_i(s1_vec), .sel_i(pat_rd[S1_LSB +: NC*SW]),
    .neg_i(pat_rd[NEG_BIT]), .vec_o(s1_swz)
  );

  shd_swizzle #(.CW(CW), .NC(NC)) swz_b_i (
    .vec_i(s2_vec), .sel_i(pat_rd[S2_LSB +: NC*SW]),
    .neg_i(1'b0), .vec_o(s2_swz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_valid <= 1'b0;
      opnd_a     <= '0;
      opnd_b     <= '0;
    end else begin
      opnd_valid <= issue_valid;
      if (issue_valid) begin
        opnd_a <= s1_swz;
        opnd_b <= s2_swz;
      end
    end
  end

  // load, write-back and output read
  rclass_e        wb_cls;
  logic [NC-1:0]  wb_mask;
  logic [UIW-1:0] ld_uni;

  assign wb_cls  = dst_class(wb_dst, N_OUT);
  assign wb_mask = pat_wb[MASK_LSB +: NC];
  assign ld_uni  = UIW'(ld_addr - AW'(UNI_BASE));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q        <= '0;
      uni_q       <= '0;
      tmp_q       <= '0;
      out_q       <= '0;
      out_rd_data <= '0;
    end else begin
      if (ld_we) begin
        unique case (src1_class(ld_addr))
          CLS_IN:  in_q[IIW'(ld_addr)] <= ld_data;
          CLS_UNI: if (ld_uni < UIW'(N_UNI)) uni_q[ld_uni] <= ld_data;
          default: ;
        endcase
      end
      for (int c = 0; c < NC; c++) begin
        if (wb_valid && wb_mask[c]) begin
          if (wb_cls == CLS_OUT)
            out_q[OIW'(wb_dst)][c*CW +: CW] <= wb_data[c*CW +: CW];
          else if (wb_cls == CLS_TMP)
            tmp_q[TIW'(wb_dst)][c*CW +: CW] <= wb_data[c*CW +: CW];
        end
      end
      out_rd_data <= (int'(out_rd_idx) < N_OUT) ? out_q[out_rd_idx] : '0;
    end
  end
endmodule

// File: rtl/shd_operand_chk.sv
module shd_operand_chk #(
  parameter int VW    = 96,
  parameter int AW    = 7,
  parameter int N_OUT = 7,
  parameter int N_TMP = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     issue_valid,
  input logic                     opnd_valid,
  input logic [VW-1:0]            opnd_a,
  input logic [VW-1:0]            opnd_b,
  input logic                     wb_valid,
  input logic [AW-1:0]            wb_dst,
  input logic [N_OUT-1:0][VW-1:0] out_q,
  input logic [N_TMP-1:0][VW-1:0] tmp_q
);
  // R7
  issue_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> opnd_valid);

  // R7
  idle_holds_operands_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> (!opnd_valid && $stable(opnd_a) && $stable(opnd_b)));

  // R6
  no_output_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(wb_valid && int'(wb_dst) < N_OUT) |=> $stable(out_q));

  // R6
  no_temp_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(wb_valid && int'(wb_dst) >= 16 && int'(wb_dst) < 32) |=> $stable(tmp_q));
endmodule

bind shd_operand_stage shd_operand_chk #(
  .VW(VW), .AW(AW), .N_OUT(N_OUT), .N_TMP(N_TMP)
) chk_i (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .opnd_valid(opnd_valid),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .wb_valid(wb_valid), .wb_dst(wb_dst),
  .out_q(out_q), .tmp_q(tmp_q)
);

// File: tb/shd_operand_stage_tb_top.sv
`timescale 1ns/1ps
module shd_operand_stage_tb_top;
  localparam int VW = 96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          pat_we = 0;
  logic [9:0]    pat_waddr = '0;
  logic [20:0]   pat_wdata = '0;
  logic          ld_we = 0;
  logic [6:0]    ld_addr = '0;
  logic [VW-1:0] ld_data = '0;
  logic          issue_valid = 0;
  logic [6:0]    src1_addr = '0, src2_addr = '0;
  logic [9:0]    issue_desc = '0;
  logic          opnd_valid;
  logic [VW-1:0] opnd_a, opnd_b;
  logic          wb_valid = 0;
  logic [6:0]    wb_dst = '0;
  logic [9:0]    wb_desc = '0;
  logic [VW-1:0] wb_data = '0;
  logic [2:0]    out_rd_idx = '0;
  logic [VW-1:0] out_rd_data;

  shd_operand_stage dut_i (.*);

  int nchk = 0, nfail = 0;

  // model state
  logic [VW-1:0] m_in [16];
  logic [VW-1:0] m_uni [96];
  logic [VW-1:0] m_tmp [16];
  logic [VW-1:0] m_out [7];
  logic [20:0]   m_pat [1024];

  function automatic logic [23:0] cval(input int cls, input int idx, input int c);
    return {cls[3:0], idx[7:0], c[3:0], 8'h3C};
  endfunction

  function automatic logic [VW-1:0] vec(input int cls, input int idx);
    logic [VW-1:0] v;
    for (int c = 0; c < 4; c++) v[c*24 +: 24] = cval(cls, idx, c);
    return v;
  endfunction

  function automatic logic [20:0] mkpat(input logic [3:0] m, input logic n,
                                        input logic [7:0] s1, input logic [7:0] s2);
    return {s2, s1, n, m};
  endfunction

  function automatic logic [VW-1:0] swz(input logic [VW-1:0] v, input logic [7:0] s, input logic n);
    logic [VW-1:0] r;
    for (int c = 0; c < 4; c++) begin
      r[c*24 +: 24] = v[int'(s[2*c +: 2])*24 +: 24];
      if (n) r[c*24 + 23] = ~r[c*24 + 23];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] fetch1(input logic [6:0] a);
    if (a < 7'h10) return m_in[a[3:0]];
    if (a < 7'h20) return m_tmp[a[3:0]];
    return m_uni[int'(a) - 32];
  endfunction

  function automatic logic [VW-1:0] fetch2(input logic [6:0] a);
    if (a < 7'h10) return m_in[a[3:0]];
    return m_tmp[a[3:0]];
  endfunction

  task automatic check(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic write_pat(input int idx, input logic [20:0] p);
    pat_we = 1; pat_waddr = 10'(idx); pat_wdata = p;
    @(negedge clk);
    pat_we = 0;
    m_pat[idx] = p;
  endtask

  task automatic load(input logic [6:0] a, input logic [VW-1:0] d);
    ld_we = 1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 0;
    if (a < 7'h10) m_in[a[3:0]] = d;
    else if (a >= 7'h20) m_uni[int'(a) - 32] = d;
  endtask

  task automatic model_wb(input logic [6:0] d, input int desc, input logic [VW-1:0] v);
    for (int c = 0; c < 4; c++) if (m_pat[desc][c]) begin
      if (d < 7'd7) m_out[d][c*24 +: 24] = v[c*24 +: 24];
      else if (d >= 7'h10 && d < 7'h20) m_tmp[d[3:0]][c*24 +: 24] = v[c*24 +: 24];
    end
  endtask

  task automatic do_wb(input logic [6:0] d, input int desc, input logic [VW-1:0] v);
    wb_valid = 1; wb_dst = d; wb_desc = 10'(desc); wb_data = v;
    @(negedge clk);
    wb_valid = 0;
    model_wb(d, desc, v);
  endtask

  task automatic do_issue(input string req, input logic [6:0] a, input logic [6:0] b, input int desc);
    logic [VW-1:0] ea, eb;
    ea = swz(fetch1(a), m_pat[desc][12:5], m_pat[desc][4]);
    eb = swz(fetch2(b), m_pat[desc][20:13], 1'b0);
    issue_valid = 1; src1_addr = a; src2_addr = b; issue_desc = 10'(desc);
    @(negedge clk);
    issue_valid = 0;
    check({req, " valid"}, {95'd0, opnd_valid}, {95'd0, 1'b1});
    check({req, " opnd_a"}, opnd_a, ea);
    check({req, " opnd_b"}, opnd_b, eb);
  endtask

  task automatic read_out(input string req, input int idx);
    out_rd_idx = 3'(idx);
    @(negedge clk);
    check(req, out_rd_data, m_out[idx]);
  endtask

  // stimulus vectors: {src1, src2, desc}
  localparam int NV = 9;
  localparam logic [23:0] VTBL [NV] = '{
    {7'h03, 7'h0F, 10'd0},
    {7'h1A, 7'h10, 10'd1},
    {7'h20, 7'h45, 10'd2},
    {7'h7F, 7'h7E, 10'd1023},
    {7'h15, 7'h03, 10'd3},
    {7'h5C, 7'h1F, 10'd1},
    {7'h0A, 7'h00, 10'd1023},
    {7'h11, 7'h08, 10'd0},
    {7'h40, 7'h2B, 10'd3}
  };

  initial begin
    logic [VW-1:0] old_v;
    for (int i = 0; i < 16; i++) begin m_in[i] = '0; m_tmp[i] = '0; end
    for (int i = 0; i < 96; i++) m_uni[i] = '0;
    for (int i = 0; i < 7; i++) m_out[i] = '0;
    for (int i = 0; i < 1024; i++) m_pat[i] = '0;

    repeat (3) @(negedge clk);
    rst = 0;
    // R11: reset state
    check("R11 opnd_valid", {95'd0, opnd_valid}, '0);
    check("R11 opnd_a", opnd_a, '0);
    check("R11 opnd_b", opnd_b, '0);
    read_out("R11 out_rd_data", 3);

    // R12: pattern table writes, including last index
    write_pat(0,    mkpat(4'hF, 1'b0, 8'hE4, 8'hE4));
    write_pat(1,    mkpat(4'h5, 1'b1, 8'h1B, 8'h00));
    write_pat(2,    mkpat(4'h0, 1'b0, 8'hFF, 8'h4E));
    write_pat(3,    mkpat(4'h3, 1'b0, 8'hAA, 8'h55));
    write_pat(1023, mkpat(4'hA, 1'b1, 8'h39, 8'h93));

    do_issue("R11 regfile cleared", 7'h05, 7'h15, 0);

    // R9: loads
    for (int i = 0; i < 16; i++) load(7'(i), vec(1, i));
    for (int i = 0; i < 96; i++) load(7'(32 + i), vec(9, i));
    // R5: fill temporaries through write-back
    for (int i = 0; i < 16; i++) do_wb(7'(16 + i), 0, vec(5, i));
    // R9: load into temporary range is ignored
    load(7'h15, {VW{1'b1}});

    // R1 R2 R3 R4 R12: vector table
    for (int v = 0; v < NV; v++)
      do_issue($sformatf("R1 R2 R3 R4 vec%0d", v), VTBL[v][23:17], VTBL[v][16:10], int'(VTBL[v][9:0]));

    // R5 R10: masked writes to output 2
    do_wb(7'h02, 1, vec(7, 2));
    read_out("R5 R10 out2 mask5", 2);
    do_wb(7'h02, 1023, vec(6, 2));
    read_out("R5 out2 maskA", 2);
    // R5: mask of zero writes nothing
    do_wb(7'h04, 2, vec(7, 4));
    read_out("R5 out4 mask0", 4);

    // R6: destinations outside both ranges
    do_wb(7'h07, 0, vec(3, 7));
    do_wb(7'h08, 0, vec(3, 8));
    do_wb(7'h0D, 0, vec(3, 13));
    do_wb(7'h25, 0, vec(3, 37));
    do_wb(7'h7F, 0, vec(3, 127));
    for (int i = 0; i < 7; i++) read_out($sformatf("R6 out%0d", i), i);
    do_issue("R6 tmp5", 7'h15, 7'h1D, 0);
    do_issue("R6 tmp15", 7'h1F, 7'h18, 0);

    // R5: masked temporary write
    do_wb(7'h13, 1023, vec(4, 3));
    do_issue("R5 tmp3 maskA", 7'h13, 7'h13, 0);

    // R8: issue and write-back to the same temporary on one edge
    old_v = m_tmp[4];
    issue_valid = 1; src1_addr = 7'h14; src2_addr = 7'h14; issue_desc = 10'd0;
    wb_valid = 1; wb_dst = 7'h14; wb_desc = 10'd0; wb_data = vec(2, 4);
    @(negedge clk);
    issue_valid = 0; wb_valid = 0;
    model_wb(7'h14, 0, vec(2, 4));
    check("R8 old value a", opnd_a, old_v);
    check("R8 old value b", opnd_b, old_v);
    do_issue("R8 new value", 7'h14, 7'h14, 0);

    // R7: back-to-back issues, then hold
    issue_valid = 1; src1_addr = 7'h01; src2_addr = 7'h02; issue_desc = 10'd0;
    @(negedge clk);
    check("R7 b2b first", opnd_a, m_in[1]);
    src1_addr = 7'h21; src2_addr = 7'h11;
    @(negedge clk);
    issue_valid = 0;
    check("R7 b2b second a", opnd_a, m_uni[1]);
    check("R7 b2b second b", opnd_b, m_tmp[1]);
    src1_addr = 7'h05;
    repeat (3) @(negedge clk);
    check("R7 hold valid", {95'd0, opnd_valid}, '0);
    check("R7 hold a", opnd_a, m_uni[1]);
    check("R7 hold b", opnd_b, m_tmp[1]);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule